// File: doc/BRIEF.md
# TRS Sync-Bit Inserter

This block sits ahead of the scrambler in a 6G or 12G serial video transmit path. It watches a 10-bit parallel word stream for runs of repeated all-ones (3FFh) or all-zeros (000h) words, such as those found in timing-reference preambles. In each such word it overwrites the two low bits with a fixed sync code. This breaks up the very long runs of identical bits that would otherwise reach the scrambler and can produce a pathological output pattern. The one exception is a single complete 3FFh, 000h, 000h sequence, which is passed through unmodified so that the receiver can still find word alignment.

To decide whether a 3FFh word is the last one of its run, the block must see the words that come after it. A three-word window therefore delays the stream. The window advances only on cycles where the input is valid. Each word leaves the block on the cycle after the third valid word that follows it has been accepted. This delay is the same whether insertion is active or not. A rate-select input turns insertion on for the 6G and 12G rates. At every other rate the words pass through unchanged but keep the same delay.

Top module: `trs_sync_inserter`

## Requirements
- R1: Words that are not part of a run leave unchanged, in order. The word accepted on the k-th valid input cycle appears on the output in the cycle after the (k+3)-th valid input cycle.
- R2: Insertion is active only when `rate_sel` is 2'b10 (6G) or 2'b11 (12G). With 2'b00 or 2'b01 every word passes unmodified with the same latency. The rate is taken in the cycle in which the word leaves the window.
- R3: A 000h word that belongs to a run is output as 002h: bits [1:0] become 2'b10 and bits [9:2] stay zero.
- R4: A 3FFh word that belongs to a run is output as 3FDh: bits [1:0] become 2'b01 and bits [9:2] stay all ones.
- R5: A word belongs to a run when it is 3FFh or 000h and the valid word just before it or just after it has the same value. A lone 3FFh or 000h is never modified.
- R6: When a 3FFh word is immediately followed by two 000h words, all three are output unmodified. A 000h that follows those two is still modified.
- R7: Cycles with `in_valid` low neither advance the window nor break or extend a run. `out_valid` is high only in the cycle after a valid input cycle that pushes a filled stage out.
- R8: A synchronous reset empties the window. Afterwards `out_valid` is low and `out_data` is zero until three new valid words have been accepted. While `out_valid` is low, `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate code; 2'b10 and 2'b11 enable insertion |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 10 | Input video word |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 10 | Output word, zero when not valid |

## Verification
The stream mixes several kinds of input. Long 3FFh runs followed by longer 000h runs show that only the boundary triple survives. Lone 3FFh and 000h words, along with a 3FFh followed by just one 000h, separate a run from a single occurrence. Short 3FFh-000h-000h bursts with nothing around them check that the preserved triple is found even without a run before it. Idle gaps inserted inside runs show that run detection spans cycles with valid low. The rate code is changed while the same patterns are replayed, which separates bypass from insertion at an identical latency. A reset in mid-stream checks that the window refills from empty.

// File: rtl/trs_sync_pkg.sv
package trs_sync_pkg;

   typedef enum logic [1:0] {
      RATE_SD  = 2'b00,
      RATE_3G  = 2'b01,
      RATE_6G  = 2'b10,
      RATE_12G = 2'b11
   } rate_e;

   // sync codes placed in the two low bits of a modified word
   localparam logic [1:0] SYNC_ONES  = 2'b01;
   localparam logic [1:0] SYNC_ZEROS = 2'b10;

   function automatic logic rate_inserts(input logic [1:0] r);
      return (r == RATE_6G) || (r == RATE_12G);
   endfunction

endpackage

// File: rtl/trs_word_window.sv
module trs_word_window #(
   parameter int W     = 10,
   parameter int AHEAD = 2,
   parameter int BEHIND = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     wd [AHEAD+BEHIND+1],
   output logic             wv [AHEAD+BEHIND+1]
);
   localparam int SLOTS = AHEAD + BEHIND + 1;

   // slot 0 newest; slot AHEAD is the word being decided
   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst) begin
               wd[k] <= '0;
               wv[k] <= 1'b0;
            end else if (adv) begin
               if (k == 0) begin
                  wd[k] <= din;
                  wv[k] <= 1'b1;
               end else begin
                  wd[k] <= wd[(k == 0) ? 0 : k-1];
                  wv[k] <= wv[(k == 0) ? 0 : k-1];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/trs_sync_decide.sv
module trs_sync_decide
   import trs_sync_pkg::*;
#(
   parameter int W            = 10,
   parameter bit KEEP_PREAMBLE = 1'b1
) (
   input  logic             en,
   // n2: two ahead, n1: one ahead, x: current, p1/p2: behind
   input  logic [W-1:0]     n2, n1, x, p1, p2,
   input  logic             n2v, n1v, xv, p1v, p2v,
   output logic [W-1:0]     y
);
   localparam logic [W-1:0] ONES  = {W{1'b1}};
   localparam logic [W-1:0] ZEROS = '0;

   logic is1, is0, in_run, keep;

   always_comb begin
      is1    = xv && (x == ONES);
      is0    = xv && (x == ZEROS);
      in_run = (is1 || is0) && ((p1v && p1 == x) || (n1v && n1 == x));
   end

   generate
      if (KEEP_PREAMBLE) begin : g_keep
         logic head, mid, tail;
         always_comb begin
            head = is1 && n1v && n2v && (n1 == ZEROS) && (n2 == ZEROS);
            mid  = is0 && p1v && n1v && (p1 == ONES) && (n1 == ZEROS);
            tail = is0 && p1v && p2v && (p2 == ONES) && (p1 == ZEROS);
            keep = head || mid || tail;
         end
      end else begin : g_nokeep
         always_comb keep = 1'b0;
      end
   endgenerate

   always_comb begin
      y = x;
      if (en && in_run && !keep)
         y[1:0] = is1 ? SYNC_ONES : SYNC_ZEROS;
   end

endmodule

// File: rtl/trs_sync_inserter.sv
module trs_sync_inserter
   import trs_sync_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   rate_sel,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int AHEAD  = 2;
   localparam int BEHIND = 2;
   localparam int SLOTS  = AHEAD + BEHIND + 1;
   localparam int CUR    = AHEAD;

   generate
      if (W < 3) begin : g_bad_width
         $error("trs_sync_inserter: W must be at least 3");
      end
   endgenerate

   logic [W-1:0] wd [SLOTS];
   logic         wv [SLOTS];
   logic [W-1:0] dec_word;

   trs_word_window #(.W(W), .AHEAD(AHEAD), .BEHIND(BEHIND)) u_win (
      .clk (clk),
      .rst (rst),
      .adv (in_valid),
      .din (in_data),
      .wd  (wd),
      .wv  (wv)
   );

   trs_sync_decide #(.W(W), .KEEP_PREAMBLE(1'b1)) u_dec (
      .en  (rate_inserts(rate_sel)),
      .n2  (wd[0]), .n1 (wd[1]), .x (wd[CUR]), .p1 (wd[3]), .p2 (wd[4]),
      .n2v (wv[0]), .n1v(wv[1]), .xv(wv[CUR]), .p1v(wv[3]), .p2v(wv[4]),
      .y   (dec_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_valid && wv[CUR]) begin
         out_valid <= 1'b1;
         out_data  <= dec_word;
      end else begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end
   end

   // R8: first edge after reset shows an empty output
   a_r8_reset_empty: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_data == '0));

   // R7: an idle input cycle never yields an output word
   a_r7_idle_no_output: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R3 / R4: only the two low bits may differ from the window word
   a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wv[CUR]) |=> (out_data[W-1:2] == $past(wd[CUR][W-1:2])));

   // R4: any change is exactly 3FF->3FD or 000->002
   a_r4_change_codes: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wv[CUR]) |=>
         (out_data == $past(wd[CUR])) ||
         ($past(wd[CUR]) == {W{1'b1}} && out_data == {{(W-2){1'b1}}, SYNC_ONES}) ||
         ($past(wd[CUR]) == '0 && out_data == {{(W-2){1'b0}}, SYNC_ZEROS}));

   // R2: low rates pass the word through untouched
   a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && wv[CUR] && !rate_inserts(rate_sel)) |=> (out_data == $past(wd[CUR])));

endmodule

// File: tb/sim_trs_sync_inserter.sv
module sim_trs_sync_inserter;
   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] rate_sel;
   logic       in_valid;
   logic [9:0] in_data;
   logic       out_valid;
   logic [9:0] out_data;

   always #2.5 clk = ~clk;   // 200 MHz

   trs_sync_inserter #(.W(10)) u0 (
      .clk(clk), .rst(rst), .rate_sel(rate_sel),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   int checks = 0;
   int fails  = 0;
   logic [9:0] q[$];
   logic       exp_v;
   logic [9:0] exp_d;
   string      exp_tag;
   bit         done = 0;

   function automatic logic [9:0] ref_word(int i, bit en, output string tag);
      logic [9:0] x = q[i];
      bit same_prev = (i >= 1) && (q[i-1] == x);
      bit same_next = (q[i+1] == x);
      bit run, keep;
      run  = ((x == 10'h3FF) || (x == 10'h000)) && (same_prev || same_next);
      keep = (x == 10'h3FF && q[i+1] == 10'h000 && q[i+2] == 10'h000) ||
             (x == 10'h000 && i >= 1 && q[i-1] == 10'h3FF && q[i+1] == 10'h000) ||
             (x == 10'h000 && i >= 2 && q[i-2] == 10'h3FF && q[i-1] == 10'h000);
      if (!en)            begin tag = "R2"; return x; end
      if (run && keep)    begin tag = "R6"; return x; end
      if (run && x == 10'h3FF) begin tag = "R4"; return 10'h3FD; end
      if (run)            begin tag = "R3"; return 10'h002; end
      tag = ((x == 10'h3FF) || (x == 10'h000)) ? "R5" : "R1";
      return x;
   endfunction

   task automatic check_out();
      checks++;
      if (out_valid !== exp_v || out_data !== exp_d) begin
         fails++;
         $display("FAIL %s: got valid=%0b data=%03h, expected valid=%0b data=%03h",
                  exp_tag, out_valid, out_data, exp_v, exp_d);
      end
   endtask

   // check previous result, then drive next inputs and predict
   task automatic step(bit v, logic [9:0] d, logic [1:0] r);
      string t;
      @(negedge clk);
      check_out();
      rst = 1'b0; in_valid = v; in_data = d; rate_sel = r;
      if (v) begin
         int n = q.size();
         q.push_back(d);
         if (n >= 3) begin
            exp_v = 1'b1;
            exp_d = ref_word(n - 3, r[1], t);
            exp_tag = t;
         end else begin
            exp_v = 1'b0; exp_d = '0; exp_tag = "R8";
         end
      end else begin
         exp_v = 1'b0; exp_d = '0; exp_tag = "R7";
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      if (q.size() > 0) check_out();
      rst = 1'b1; in_valid = 1'b0; in_data = 10'h155;
      q.delete();
      repeat (2) @(negedge clk);
      // R8: empty output while and after reset
      checks++;
      if (out_valid !== 1'b0 || out_data !== 10'h000) begin
         fails++;
         $display("FAIL R8: got valid=%0b data=%03h, expected valid=0 data=000",
                  out_valid, out_data);
      end
      exp_v = 1'b0; exp_d = '0; exp_tag = "R8";
   endtask

   task automatic send(logic [9:0] d, int cnt, logic [1:0] r);
      for (int k = 0; k < cnt; k++) step(1'b1, d, r);
   endtask

   task automatic pattern(logic [1:0] r);
      send(10'h123, 3, r);                    // R1 plain words
      send(10'h3FF, 4, r); send(10'h000, 5, r); // R3 R4 R6
      send(10'h2AA, 1, r);
      send(10'h3FF, 1, r); send(10'h000, 1, r); // R5 lone words
      send(10'h155, 1, r);
      send(10'h000, 1, r); send(10'h3FF, 1, r); send(10'h0AB, 1, r);
      send(10'h3FF, 1, r); send(10'h000, 2, r); // R6 bare triple
      send(10'h3FF, 1, r); send(10'h000, 1, r); send(10'h3FF, 1, r);
      // R7 idle gaps inside runs
      send(10'h3FF, 2, r); step(1'b0, 10'h3FF, r); step(1'b0, 10'h000, r);
      send(10'h3FF, 1, r); step(1'b0, 10'h111, r);
      send(10'h000, 1, r); step(1'b0, 10'h000, r); send(10'h000, 2, r);
      send(10'h201, 2, r);
   endtask

   initial begin
      rst = 1'b1; rate_sel = 2'b00; in_valid = 1'b0; in_data = '0;
      exp_v = 1'b0; exp_d = '0; exp_tag = "R8";
      do_reset();
      pattern(2'b11);
      pattern(2'b10);
      pattern(2'b00);
      pattern(2'b01);
      send(10'h3FF, 3, 2'b11);
      do_reset();                              // R8 mid-stream reset
      send(10'h000, 6, 2'b10);
      send(10'h3FF, 2, 2'b10);
      send(10'h000, 3, 2'b10);
      send(10'h0F0, 4, 2'b10);
      step(1'b0, 10'h000, 2'b10);
      @(negedge clk);
      check_out();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: got hung run, expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule